// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets on-chip logic reach external parallel devices over a bus whose pins carry the address first and the data after it. An internal requester hands over one read or write at a time. The block then runs a fixed three-cycle access on the shared pins. The first cycle is the address cycle, which puts the address on the pins and pulses a latch strobe so an external latch can hold the address. The next two cycles are the data cycles, with the active-low read or write strobe low. On a read, the pin value present at the end of the second data cycle is captured and returned to the requester with a one-cycle valid pulse.

Two static configuration inputs set the pin behaviour. One sets the polarity of the latch strobe. The other sets how devices are selected:
- latch strobe only, for one device;
- the latch pin reused as a single active-low select that covers the whole access;
- two or four active-low selects, decoded from the top one or two address bits and asserted in the same cycle as the latch strobe.

The shared pins are modelled as separate output, output-enable and input signals.

Top module: `muxbus_master`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, the block holds these values: busy=0, rd_n=1, wr_n=1, sel_n=4'hF, ad_oe=0, rsp_valid=0. The latch pin is at its inactive level: the opposite of cfg_latch_high in modes 0, 2 and 3, and 1 in mode 1.
- R2: A request with req_valid=1, sampled while busy=0, starts an address cycle on the next clock. In that cycle ad_out equals req_addr zero-extended, ad_oe=1, and the latch pin is at its active level. Two data cycles follow, and during them the latch pin is inactive.
- R3: On a read (req_write=0), rd_n is low in both data cycles and ad_oe=0. In the cycle after the second data cycle, rsp_valid is 1 for exactly one cycle, and rsp_rdata equals the ad_in value sampled at the clock edge that ends the second data cycle.
- R4: On a write (req_write=1), wr_n is low in both data cycles, ad_oe=1 and ad_out equals req_wdata. No rsp_valid pulse follows a write.
- R5: In modes 0, 2 and 3, the latch pin's active level is high when cfg_latch_high=1 and low when cfg_latch_high=0.
- R6: With cfg_sel_mode=1 (single select), the latch pin is low through the address cycle and both data cycles and high otherwise. sel_n stays 4'hF.
- R7: With cfg_sel_mode=2 (dual), sel_n[a] is low from the address cycle through the second data cycle, where a is the top address bit. Every other select stays high. The select asserts in the same cycle as the latch strobe.
- R8: With cfg_sel_mode=3 (quad), the same rule as R7 applies, with the index taken from the top two address bits.
- R9: With cfg_sel_mode=0 (latch only), sel_n stays 4'hF at all times.
- R10: busy is 1 for exactly the three access cycles. A request raised while busy=1 and dropped before busy falls is ignored. Back-to-back requests are separated by exactly one cycle with busy=0.
- R11: rd_n and wr_n are never low together, and ad_oe is 0 whenever rd_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel_mode | input | 2 | 0 latch only, 1 single select on latch pin, 2 dual select, 3 quad select |
| cfg_latch_high | input | 1 | 1: latch strobe active high, 0: active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress; new requests are not taken |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_latch | output | 1 | Address latch strobe, or single active-low select in mode 1 |
| bus_sel_n | output | 4 | Active-low device selects (modes 2 and 3) |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ad_out | output | DATA_W | Shared pins, driven value |
| bus_ad_oe | output | 1 | Shared pins, output enable |
| bus_ad_in | input | DATA_W | Shared pins, sampled value |

## Verification
The assertions check several rules on every cycle:
- the read and write strobes are never low together;
- the output enable is released while reading;
- at most one select is low, and a select goes with the latch strobe in the decoded modes;
- latch-only mode never asserts a select;
- a response always follows a read strobe, and the read strobe stays low for at least two cycles.

Only the bench's scenarios can show the rest:
- the exact values on the pins in each phase;
- which select a given address decodes to;
- the captured read data;
- that a request raised during an access is dropped;
- that back-to-back requests are separated by exactly one idle cycle.

// File: rtl/muxbus_pkg.sv
// Shared types for the multiplexed bus master.
// Assumes at most four external device selects.
package muxbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DAT1 = 2'd2,
        PH_DAT2 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_LATCH  = 2'd0,
        SEL_SINGLE = 2'd1,
        SEL_DUAL   = 2'd2,
        SEL_QUAD   = 2'd3
    } selmode_e;

    localparam int unsigned NUM_SEL = 4;
endpackage

// File: rtl/muxbus_seq.sv
// Access sequencer: takes one request while idle and steps through one address
// cycle and two data cycles, then one idle cycle.
// Assumes the requester keeps the request stable in the cycle it is sampled.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output phase_e            phase,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              busy
);
    logic take;

    // Accept a request only while idle.
    assign take = (phase == PH_IDLE) && req_valid;

    // Phase register advancing through a fixed three-cycle access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: phase <= take ? PH_ADDR : PH_IDLE;
                PH_ADDR: phase <= PH_DAT1;
                PH_DAT1: phase <= PH_DAT2;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (take) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    // Busy for the three access cycles.
    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/muxbus_seldec.sv
// Device select decoder: in dual or quad mode drives one active-low select
// for the whole access, picked by the top one or two address bits.
// Assumes ADDR_W >= 2.
module muxbus_seldec
    import muxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  phase_e            phase,
    input  selmode_e          mode,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [NUM_SEL-1:0] sel_n
);
    logic       in_access;
    logic       decode_en;
    logic [1:0] idx;

    // Select index depends on how many devices are configured.
    always_comb begin
        in_access = (phase != PH_IDLE);
        decode_en = (mode == SEL_DUAL) || (mode == SEL_QUAD);
        if (mode == SEL_QUAD) begin
            idx = cur_addr[ADDR_W-1 -: 2];
        end else begin
            idx = {1'b0, cur_addr[ADDR_W-1]};
        end
    end

    // One comparator per select line.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_n[g] = !(in_access && decode_en && (idx == 2'(g)));
    end
endmodule

// File: rtl/muxbus_pins.sv
// Pin driver: latch strobe or single select, read/write strobes and the
// driven value and enable of the shared pins, decoded from the phase.
// Assumes ADDR_W <= DATA_W; the address is zero-extended.
module muxbus_pins
    import muxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  phase_e            phase,
    input  selmode_e          mode,
    input  logic              latch_high,
    input  logic              cur_write,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic              latch_pin,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);
    logic in_data;

    // Latch pin: single select in mode 1, else a strobe on the address cycle.
    always_comb begin
        if (mode == SEL_SINGLE) begin
            latch_pin = (phase == PH_IDLE);
        end else if (phase == PH_ADDR) begin
            latch_pin = latch_high;
        end else begin
            latch_pin = !latch_high;
        end
    end

    // Strobes and shared pin drive for address and data cycles.
    always_comb begin
        in_data = (phase == PH_DAT1) || (phase == PH_DAT2);
        rd_n    = !(in_data && !cur_write);
        wr_n    = !(in_data && cur_write);
        ad_out  = '0;
        ad_oe   = 1'b0;
        if (phase == PH_ADDR) begin
            ad_out = DATA_W'(cur_addr);
            ad_oe  = 1'b1;
        end else if (in_data && cur_write) begin
            ad_out = cur_wdata;
            ad_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/muxbus_rdcap.sv
// Read capture: samples the shared pins at the edge that ends the second
// read data cycle and presents them with a one-cycle valid.
// Assumes the external device holds data valid up to that edge.
module muxbus_rdcap
    import muxbus_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic cap;

    // Capture on the last read data cycle.
    assign cap = (phase == PH_DAT2) && !cur_write;

    // Register read data and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap;
            if (cap) begin
                rsp_rdata <= ad_in;
            end
        end
    end
endmodule

// File: rtl/muxbus_master.sv
// Multiplexed address/data bus master top level.
// Runs one access at a time: address cycle, two data cycles, one idle cycle.
// Assumes cfg_sel_mode and cfg_latch_high change only while busy is low.
module muxbus_master
    import muxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_sel_mode,
    input  logic              cfg_latch_high,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_latch,
    output logic [3:0]        bus_sel_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in
);
    phase_e            phase;
    selmode_e          mode;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    // Decode the raw mode input into the enumerated type.
    assign mode = selmode_e'(cfg_sel_mode);

    muxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .busy      (busy)
    );

    muxbus_seldec #(.ADDR_W(ADDR_W)) u_seldec (
        .phase    (phase),
        .mode     (mode),
        .cur_addr (cur_addr),
        .sel_n    (bus_sel_n)
    );

    muxbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase      (phase),
        .mode       (mode),
        .latch_high (cfg_latch_high),
        .cur_write  (cur_write),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .latch_pin  (bus_latch),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .ad_out     (bus_ad_out),
        .ad_oe      (bus_ad_oe)
    );

    muxbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .cur_write (cur_write),
        .ad_in     (bus_ad_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/muxbus_master_chk.sv
// Protocol checker for muxbus_master, attached by bind.
// Assumes the configuration inputs are static during an access.
module muxbus_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_sel_mode,
    input logic       cfg_latch_high,
    input logic       busy,
    input logic       rsp_valid,
    input logic       bus_latch,
    input logic [3:0] bus_sel_n,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic       bus_ad_oe
);
    // Read and write strobes are exclusive.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // Pins are released while reading.
    p_oe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    // At most one device select active.
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_sel_n));

    // Latch strobe and a select go together in dual/quad mode.
    p_sel_with_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_mode[1] && (bus_latch == cfg_latch_high)) |-> (bus_sel_n != 4'hF));

    // Latch-only mode drives no select.
    p_no_sel_latch_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_mode == 2'd0) |-> (bus_sel_n == 4'hF));

    // Single select released while idle.
    p_single_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_sel_mode == 2'd1) && !busy) |-> bus_latch);

    // A response follows a read strobe.
    p_rsp_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(bus_rd_n) == 1'b0));

    // Read strobe spans at least two cycles.
    p_rd_two_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |=> !bus_rd_n);

    // Busy lasts more than one cycle.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

bind muxbus_master muxbus_master_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_sel_mode   (cfg_sel_mode),
    .cfg_latch_high (cfg_latch_high),
    .busy           (busy),
    .rsp_valid      (rsp_valid),
    .bus_latch      (bus_latch),
    .bus_sel_n      (bus_sel_n),
    .bus_rd_n       (bus_rd_n),
    .bus_wr_n       (bus_wr_n),
    .bus_ad_oe      (bus_ad_oe)
);

// File: tb/sim_muxbus_master.sv
// Bench for muxbus_master: a vector table of accesses, then directed tests.
module sim_muxbus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_sel_mode = 2'd0;
    logic        cfg_latch_high = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] bus_ad_in = '0;
    logic        busy, rsp_valid, bus_latch, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [15:0] rsp_rdata, bus_ad_out;
    logic [3:0]  bus_sel_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    muxbus_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_sel_mode(cfg_sel_mode),
        .cfg_latch_high(cfg_latch_high), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_latch(bus_latch), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in)
    );

    // Vector: mode(2) pol(1) write(1) addr(16) wdata(16) rdin(16) exp_sel_n(4)
    localparam logic [55:0] VECS [10] = '{
        {2'd0, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'hA5A5, 4'hF},
        {2'd0, 1'b0, 1'b1, 16'h00FF, 16'hBEEF, 16'h0000, 4'hF},
        {2'd1, 1'b1, 1'b0, 16'h8001, 16'h0000, 16'h5A5A, 4'hF},
        {2'd1, 1'b0, 1'b1, 16'h4002, 16'hCAFE, 16'h0000, 4'hF},
        {2'd2, 1'b1, 1'b0, 16'h7FFF, 16'h0000, 16'h0F0F, 4'hE},
        {2'd2, 1'b0, 1'b1, 16'h8000, 16'h1111, 16'h0000, 4'hD},
        {2'd3, 1'b1, 1'b0, 16'hC0DE, 16'h0000, 16'hF00D, 4'h7},
        {2'd3, 1'b1, 1'b1, 16'h4ABC, 16'h2222, 16'h0000, 4'hD},
        {2'd3, 1'b0, 1'b0, 16'h8123, 16'h0000, 16'h3333, 4'hB},
        {2'd3, 1'b0, 1'b1, 16'h0001, 16'h4444, 16'h0000, 4'hE}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R9";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Idle-level checks used after reset and between accesses.
    task automatic chk_idle(input string req);
        logic exp_latch;
        exp_latch = (cfg_sel_mode == 2'd1) ? 1'b1 : !cfg_latch_high;
        chk(busy === 1'b0, req, "busy", busy, 0);
        chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, req, "rd_n/wr_n",
            {bus_rd_n, bus_wr_n}, 2'b11);
        chk(bus_sel_n === 4'hF, req, "sel_n", bus_sel_n, 4'hF);
        chk(bus_ad_oe === 1'b0, req, "ad_oe", bus_ad_oe, 0);
        chk(bus_latch === exp_latch, req, "latch", bus_latch, exp_latch);
    endtask

    // One full access, checked phase by phase. Called and returns at a negedge while idle.
    task automatic run_access(input logic [1:0] m, input logic pol, input logic wr,
                              input logic [15:0] a, input logic [15:0] wd,
                              input logic [15:0] rdin, input logic [3:0] esel);
        logic lat_act, lat_dat;
        lat_act = (m == 2'd1) ? 1'b0 : pol;
        lat_dat = (m == 2'd1) ? 1'b0 : !pol;
        cfg_sel_mode = m; cfg_latch_high = pol;
        req_write = wr; req_addr = a; req_wdata = wd; bus_ad_in = rdin;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // Address cycle
        chk(busy === 1'b1, "R10", "busy in addr", busy, 1);
        chk(bus_ad_out === a && bus_ad_oe === 1'b1, "R2", "addr drive",
            {bus_ad_oe, bus_ad_out}, {1'b1, a});
        chk(bus_latch === lat_act, (m == 2'd1) ? "R6" : "R2/R5", "latch active",
            bus_latch, lat_act);
        chk(bus_sel_n === esel, mode_tag(m), "sel_n addr", bus_sel_n, esel);
        chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R2", "strobes in addr",
            {bus_rd_n, bus_wr_n}, 2'b11);
        for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            chk(busy === 1'b1, "R10", "busy in data", busy, 1);
            chk(bus_latch === lat_dat, (m == 2'd1) ? "R6" : "R2/R5", "latch data",
                bus_latch, lat_dat);
            chk(bus_sel_n === esel, mode_tag(m), "sel_n data", bus_sel_n, esel);
            chk(!(bus_rd_n === 1'b0 && bus_wr_n === 1'b0), "R11", "strobe excl",
                {bus_rd_n, bus_wr_n}, 2'b11);
            if (wr) begin
                chk(bus_wr_n === 1'b0 && bus_rd_n === 1'b1, "R4", "write strobe",
                    {bus_rd_n, bus_wr_n}, 2'b10);
                chk(bus_ad_oe === 1'b1 && bus_ad_out === wd, "R4", "write data",
                    {bus_ad_oe, bus_ad_out}, {1'b1, wd});
            end else begin
                chk(bus_rd_n === 1'b0 && bus_wr_n === 1'b1, "R3", "read strobe",
                    {bus_rd_n, bus_wr_n}, 2'b01);
                chk(bus_ad_oe === 1'b0, "R3", "oe released", bus_ad_oe, 0);
            end
        end
        @(negedge clk);
        // Idle cycle after the access
        chk(busy === 1'b0, "R10", "busy after", busy, 0);
        if (wr) begin
            chk(rsp_valid === 1'b0, "R4", "no rsp on write", rsp_valid, 0);
        end else begin
            chk(rsp_valid === 1'b1, "R3", "rsp_valid", rsp_valid, 1);
            chk(rsp_rdata === rdin, "R3", "rsp_rdata", rsp_rdata, rdin);
        end
        chk(bus_sel_n === 4'hF, mode_tag(m), "sel_n released", bus_sel_n, 4'hF);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R3", "rsp one cycle", rsp_valid, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1");
        chk(rsp_valid === 1'b0, "R1", "rsp_valid reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // Vector table
        for (int i = 0; i < 10; i++) begin
            run_access(VECS[i][55:54], VECS[i][53], VECS[i][52], VECS[i][51:36],
                       VECS[i][35:20], VECS[i][19:4], VECS[i][3:0]);
        end

        // R10: request raised during an access is ignored
        cfg_sel_mode = 2'd2; cfg_latch_high = 1'b1;
        req_write = 1'b1; req_addr = 16'h0010; req_wdata = 16'h7777; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 16'h8020; req_wdata = 16'h9999;
        @(negedge clk);
        chk(bus_ad_out === 16'h7777, "R10", "data kept during busy", bus_ad_out, 16'h7777);
        chk(bus_sel_n === 4'hE, "R10", "select kept during busy", bus_sel_n, 4'hE);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk_idle("R10");
        @(negedge clk);
        chk_idle("R10");

        // R10: back-to-back requests separated by one idle cycle
        cfg_sel_mode = 2'd3; cfg_latch_high = 1'b0;
        req_write = 1'b0; req_addr = 16'h4000; req_valid = 1'b1;
        @(negedge clk);
        chk(busy === 1'b1 && bus_ad_out === 16'h4000, "R10", "first addr",
            {busy, bus_ad_out}, {1'b1, 16'h4000});
        req_addr = 16'hC001;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R10", "single idle gap", busy, 0);
        @(negedge clk);
        chk(busy === 1'b1 && bus_ad_out === 16'hC001, "R10", "second addr",
            {busy, bus_ad_out}, {1'b1, 16'hC001});
        chk(bus_sel_n === 4'h7, "R8", "second select", bus_sel_n, 4'h7);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk_idle("R10");

        // R1: reset in the middle of a read
        cfg_sel_mode = 2'd1; cfg_latch_high = 1'b1;
        req_write = 1'b0; req_addr = 16'h0003; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        chk(rsp_valid === 1'b0, "R1", "no rsp after reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule